// File: doc/BRIEF.md
# Looping Program Sequencer with Call Stack

This block steps through a program held in a ring buffer of 512 instructions, each 16 bytes wide. A program therefore fills 8 KiB. The sequencer keeps the fetch position, a stack pointer and an instruction budget. It presents the byte address of the current instruction on a fetch port. In the same cycle, an external decoder supplies the class of the fetched instruction, the outcome of its branch comparison, its A operand and its 8-bit immediate. The instruction executes on the next rising clock edge. One instruction completes in every cycle while the block is busy.

Subroutine calls and returns go through an on-chip stack of 64-bit entries. A taken call stores two entries: the A operand first, then the return byte address. It then jumps forward. A taken return removes both entries. It jumps back to the stored return address and reports A XOR the stored value as its C result. A call or return that is not taken, that finds the stack too full, or that finds the stack empty does nothing to the stack or to the flow, and reports C = A. The fetch position wraps around the end of the buffer, so the program is an endless loop. Only the instruction budget ends a run.

Top module: `prog_ctrl_unit`

## Requirements
- R1: While reset is held and after it is released, busy, done, fetch_req and res_valid are all 0.
- R2: When start is 1 while the block is idle, it becomes busy on the next edge with fetch_addr = 0 and an empty stack. A start while busy has no effect.
- R3: An instruction that is not a taken CALL or RET advances fetch_addr by 16 bytes, and from byte 8176 it wraps to 0.
- R4: Each run executes exactly IC_INIT instructions, one per busy cycle. On the cycle after the last one executes, done is 1 for exactly one cycle and busy and fetch_req are 0.
- R5: op_kind is encoded as 0 = plain, 1 = CALL, 2 = RET, 3 = plain. res_valid is 1 in the cycle after a CALL or RET executes and 0 after a plain instruction.
- R6: A CALL with br_take = 1 and at least two free entries pushes opnd_a and then the return address. The return address is the byte address of the following instruction, zero-extended to 64 bits. The next fetch is at return address + 16*(imm0+1), modulo 8192, and res_c = opnd_a.
- R7: A CALL or RET with br_take = 0 leaves the stack unchanged, continues in sequence and gives res_c = opnd_a.
- R8: A RET with br_take = 1 and a non-empty stack first pops the return address and then pops a value V. It gives res_c = opnd_a XOR V, and the next fetch is at the popped return address.
- R9: A RET on an empty stack behaves as not taken: res_c = opnd_a, sequential flow.
- R10: The stack holds at most 256 entries, which is 128 nested calls. A CALL that finds fewer than two free entries behaves as not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when the budget is used up |
| fetch_req | output | 1 | fetch_addr is valid this cycle |
| fetch_addr | output | 13 | Byte address of the instruction to execute |
| op_kind | input | 2 | Class of the fetched instruction |
| br_take | input | 1 | Branch comparison result (B <= imm1) |
| opnd_a | input | 64 | A operand of the fetched instruction |
| imm0 | input | 8 | 8-bit immediate of the fetched instruction |
| res_valid | output | 1 | res_c holds the C result of a CALL or RET |
| res_c | output | 64 | C result |

## Verification
On every cycle, the assertions check the following:
- the stack depth bound, and that two entries are added or removed per taken call or return;
- that a push or pop is never granted when the room or contents are missing;
- that a plain instruction advances in sequence;
- that the done pulse is single and stops fetching;
- that an empty-stack return passes A through.

Only the bench's scenarios can show the end-to-end values: the return data XORed into C, the jump targets across the wrap point, the exact instruction count per run, and that a refused call leaves the stack intact for later returns.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    K_PLAIN = 2'd0,
    K_CALL  = 2'd1,
    K_RET   = 2'd2,
    K_RSVD  = 2'd3
  } op_kind_t;
endpackage

// File: rtl/pcu_budget.sv
module pcu_budget #(
  parameter int IC_INIT = 1048576,
  parameter int IC_W    = $clog2(IC_INIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic run,
  output logic done
);
  logic [IC_W-1:0] ic;
  logic            last_exec;

  function automatic logic [IC_W-1:0] ic_dec(input logic [IC_W-1:0] v);
    return v - IC_W'(1);
  endfunction

  assign last_exec = run && (ic == IC_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      done <= 1'b0;
      ic   <= '0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (launch) begin
          run <= 1'b1;
          ic  <= IC_W'(IC_INIT);
        end
      end else begin
        ic <= ic_dec(ic);
        if (last_exec) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4
  done_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !run);
  // R4
  budget_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ic != '0));
endmodule

// File: rtl/pcu_pc.sv
module pcu_pc #(
  parameter int N_INSTR = 512,
  parameter int IMM_W   = 8,
  parameter int IDX_W   = $clog2(N_INSTR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  input  logic             sel_call,
  input  logic             sel_ret,
  input  logic [IMM_W-1:0] imm0,
  input  logic [IDX_W-1:0] ret_idx,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] seq_idx
);
  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] v);
    return (v == IDX_W'(N_INSTR - 1)) ? '0 : v + IDX_W'(1);
  endfunction

  function automatic logic [IDX_W-1:0] call_tgt(input logic [IDX_W-1:0] base,
                                                input logic [IMM_W-1:0] ofs);
    int t;
    t = (int'(base) + int'(ofs) + 1) % N_INSTR;
    return IDX_W'(t);
  endfunction

  logic [IDX_W-1:0] nxt;

  assign seq_idx = wrap_inc(idx);

  always_comb begin
    if (sel_call)     nxt = call_tgt(seq_idx, imm0);
    else if (sel_ret) nxt = ret_idx;
    else              nxt = seq_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     idx <= '0;
    else if (clear) idx <= '0;
    else if (adv)   idx <= nxt;
  end

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clear && !sel_call && !sel_ret) |=> (idx == wrap_inc($past(idx))));
  // R2
  clear_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (idx == '0));
endmodule

// File: rtl/pcu_stack.sv
module pcu_stack #(
  parameter int DEPTH = 256,
  parameter int DW    = 64,
  parameter int SP_W  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            push2,
  input  logic            pop2,
  input  logic [DW-1:0]   push_val,
  input  logic [DW-1:0]   push_ret,
  output logic            can_push,
  output logic            can_pop,
  output logic [DW-1:0]   top_ret,
  output logic [DW-1:0]   top_val,
  output logic [SP_W-1:0] sp
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_lo, wr_hi, rd_hi, rd_lo;

  assign can_push = (sp <= SP_W'(DEPTH - 2));
  assign can_pop  = (sp >= SP_W'(2));
  assign wr_lo    = PTR_W'(sp);
  assign wr_hi    = PTR_W'(sp + SP_W'(1));
  assign rd_hi    = PTR_W'(sp - SP_W'(1));
  assign rd_lo    = PTR_W'(sp - SP_W'(2));
  assign top_ret  = mem[rd_hi];
  assign top_val  = mem[rd_lo];

  always_ff @(posedge clk) begin
    if (push2) begin
      mem[wr_lo] <= push_val;
      mem[wr_hi] <= push_ret;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     sp <= '0;
    else if (clear) sp <= '0;
    else if (push2) sp <= sp + SP_W'(2);
    else if (pop2)  sp <= sp - SP_W'(2);
  end

  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SP_W'(DEPTH));
  // R10
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push2 |-> (sp + SP_W'(2) <= SP_W'(DEPTH)));
  // R9
  pop_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop2 |-> (sp >= SP_W'(2)));
  // R6
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push2 && !clear) |=> (sp == $past(sp) + SP_W'(2)));
  // R8
  pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop2 && !clear && !push2) |=> (sp == $past(sp) - SP_W'(2)));
endmodule

// File: rtl/prog_ctrl_unit.sv
module prog_ctrl_unit
  import pcu_pkg::*;
#(
  parameter int N_INSTR     = 512,
  parameter int INSTR_BYTES = 16,
  parameter int STACK_DEPTH = 256,
  parameter int DW          = 64,
  parameter int IMM_W       = 8,
  parameter int IC_INIT     = 1048576,
  localparam int IDX_W  = $clog2(N_INSTR),
  localparam int OFS_W  = $clog2(INSTR_BYTES),
  localparam int ADDR_W = IDX_W + OFS_W,
  localparam int SP_W   = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic [1:0]        op_kind,
  input  logic              br_take,
  input  logic [DW-1:0]     opnd_a,
  input  logic [IMM_W-1:0]  imm0,
  output logic              res_valid,
  output logic [DW-1:0]     res_c
);
  function automatic logic [IDX_W-1:0] addr_to_idx(input logic [DW-1:0] a);
    return IDX_W'(a >> OFS_W);
  endfunction

  function automatic logic [DW-1:0] idx_to_addr(input logic [IDX_W-1:0] i);
    return DW'({i, {OFS_W{1'b0}}});
  endfunction

  function automatic logic [DW-1:0] mix_ret(input logic [DW-1:0] a,
                                            input logic [DW-1:0] v);
    return a ^ v;
  endfunction

  op_kind_t         kind;
  logic             run, launch;
  logic             is_call, is_ret, call_go, ret_go;
  logic             can_push, can_pop;
  logic [DW-1:0]    top_ret, top_val;
  logic [SP_W-1:0]  sp;
  logic [IDX_W-1:0] idx, seq_idx;

  assign kind    = op_kind_t'(op_kind);
  assign launch  = start && !run;
  assign is_call = run && (kind == K_CALL);
  assign is_ret  = run && (kind == K_RET);
  assign call_go = is_call && br_take && can_push;
  assign ret_go  = is_ret && br_take && can_pop;

  assign busy       = run;
  assign fetch_req  = run;
  assign fetch_addr = {idx, {OFS_W{1'b0}}};

  pcu_budget #(.IC_INIT(IC_INIT)) u_budget (
    .clk(clk), .rst_n(rst_n), .launch(launch), .run(run), .done(done)
  );

  pcu_pc #(.N_INSTR(N_INSTR), .IMM_W(IMM_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .clear(launch), .adv(run),
    .sel_call(call_go), .sel_ret(ret_go), .imm0(imm0),
    .ret_idx(addr_to_idx(top_ret)), .idx(idx), .seq_idx(seq_idx)
  );

  pcu_stack #(.DEPTH(STACK_DEPTH), .DW(DW)) u_stack (
    .clk(clk), .rst_n(rst_n), .clear(launch), .push2(call_go), .pop2(ret_go),
    .push_val(opnd_a), .push_ret(idx_to_addr(seq_idx)),
    .can_push(can_push), .can_pop(can_pop),
    .top_ret(top_ret), .top_val(top_val), .sp(sp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_c     <= '0;
    end else begin
      res_valid <= is_call || is_ret;
      if (is_call || is_ret) res_c <= ret_go ? mix_ret(opnd_a, top_val) : opnd_a;
    end
  end

  // R9
  ret_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ret && (sp == '0)) |=> (res_valid && res_c == $past(opnd_a)));
  // R7
  not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_call || is_ret) && !br_take) |=> (res_c == $past(opnd_a) && sp == $past(sp)));
  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (fetch_req && fetch_addr == '0 && sp == '0));
  // R5
  plain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !is_call && !is_ret) |=> !res_valid);
endmodule

// File: tb/test_prog_ctrl_unit.sv
module test_prog_ctrl_unit;
  localparam int IC = 600;
  localparam int N  = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, fetch_req, res_valid;
  logic [12:0] fetch_addr;
  logic [1:0]  op_kind;
  logic        br_take;
  logic [63:0] opnd_a, res_c;
  logic [7:0]  imm0;

  logic [1:0]  p_kind [N];
  bit          p_take [N];
  logic [63:0] p_a    [N];
  logic [7:0]  p_imm  [N];

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  always_comb begin
    op_kind = p_kind[fetch_addr[12:4]];
    br_take = p_take[fetch_addr[12:4]];
    opnd_a  = p_a[fetch_addr[12:4]];
    imm0    = p_imm[fetch_addr[12:4]];
  end

  prog_ctrl_unit #(.IC_INIT(IC)) i_prog_ctrl_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .op_kind(op_kind),
    .br_take(br_take), .opnd_a(opnd_a), .imm0(imm0),
    .res_valid(res_valid), .res_c(res_c)
  );

  // reference model state
  bit          m_run = 0, m_done = 0, m_rv = 0;
  int          m_idx = 0, m_ic = 0, m_execs = 0;
  logic [63:0] m_c = '0;
  logic [63:0] m_stk [$];
  string       l_pc = "R2", l_c = "R5";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(fetch_req === m_run, m_done ? "R4" : "R2", "fetch_req", 64'(fetch_req), 64'(m_run));
    chk(busy === m_run, "R4", "busy", 64'(busy), 64'(m_run));
    if (m_run)
      chk(fetch_addr === 13'(m_idx * 16), l_pc, "fetch_addr", 64'(fetch_addr), 64'(m_idx * 16));
    chk(done === m_done, "R4", "done", 64'(done), 64'(m_done));
    chk(res_valid === m_rv, "R5", "res_valid", 64'(res_valid), 64'(m_rv));
    if (m_rv) chk(res_c === m_c, l_c, "res_c", res_c, m_c);
  endtask

  task automatic model_step(input bit st);
    m_done = 0;
    m_rv   = 0;
    if (m_run) begin
      int seq;
      int nidx;
      seq  = (m_idx + 1) % N;
      nidx = seq;
      l_pc = "R3";
      if (p_kind[m_idx] == 2'd1) begin
        m_rv = 1;
        m_c  = p_a[m_idx];
        if (!p_take[m_idx]) begin
          l_pc = "R7"; l_c = "R7";
        end else if (m_stk.size() > 254) begin
          l_pc = "R10"; l_c = "R10";
        end else begin
          m_stk.push_back(p_a[m_idx]);
          m_stk.push_back(64'(seq * 16));
          nidx = (seq + int'(p_imm[m_idx]) + 1) % N;
          l_pc = "R6"; l_c = "R6";
        end
      end else if (p_kind[m_idx] == 2'd2) begin
        m_rv = 1;
        m_c  = p_a[m_idx];
        if (!p_take[m_idx]) begin
          l_pc = "R7"; l_c = "R7";
        end else if (m_stk.size() < 2) begin
          l_pc = "R9"; l_c = "R9";
        end else begin
          logic [63:0] ra, rv;
          ra   = m_stk.pop_back();
          rv   = m_stk.pop_back();
          m_c  = p_a[m_idx] ^ rv;
          nidx = int'(ra[12:4]);
          l_pc = "R8"; l_c = "R8";
        end
      end
      m_idx = nidx;
      m_execs++;
      m_ic--;
      if (m_ic == 0) begin
        m_run  = 0;
        m_done = 1;
      end
    end else if (st) begin
      m_run   = 1;
      m_idx   = 0;
      m_ic    = IC;
      m_execs = 0;
      m_stk.delete();
      l_pc    = "R2";
    end
  endtask

  task automatic tick(input bit st);
    compare();
    start = st;
    model_step(st);
    @(negedge clk);
  endtask

  // one full run; a start pulse is also driven at cycle poke (ignored while busy)
  task automatic run_prog(input int poke);
    int cyc;
    tick(1'b1);
    cyc = 0;
    while (m_run && cyc < 5000) begin
      tick(cyc == poke);
      cyc++;
    end
    chk(m_execs == IC, "R4", "executed count (model)", 64'(m_execs), 64'(IC));
    chk(cyc == IC, "R4", "busy cycles", 64'(cyc), 64'(IC));
    tick(1'b0);
    tick(1'b0);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < N; i++) begin
      p_kind[i] = 2'd0;
      p_take[i] = 1'b0;
      p_a[i]    = 64'h1111_0000_0000_0000 + 64'(i);
      p_imm[i]  = 8'd0;
    end
  endtask

  task automatic t_reset();
    clear_prog();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1", "busy in reset", 64'(busy), 0);
    chk(done === 1'b0, "R1", "done in reset", 64'(done), 0);
    chk(fetch_req === 1'b0, "R1", "fetch_req in reset", 64'(fetch_req), 0);
    chk(res_valid === 1'b0, "R1", "res_valid in reset", 64'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && fetch_req === 1'b0, "R1", "idle after reset", 64'(busy), 0);
    tick(1'b0);
  endtask

  // R3 R5 R2: plain code including kind 3, runs past the end of the buffer
  task automatic t_plain_wrap();
    clear_prog();
    for (int i = 0; i < N; i++) if (i % 7 == 3) p_kind[i] = 2'd3;
    run_prog(50);
  endtask

  // R6 R7 R8 R9: basic call/return pairs and refused forms
  task automatic t_call_ret();
    clear_prog();
    p_kind[0] = 2'd1; p_take[0] = 1; p_imm[0] = 8'd3; p_a[0] = 64'hDEAD_BEEF_0123_4567;
    p_kind[5] = 2'd2; p_take[5] = 1; p_a[5] = 64'hFFFF_0000_FFFF_0000;
    p_kind[2] = 2'd2; p_take[2] = 1;
    p_kind[3] = 2'd1; p_take[3] = 0;
    p_kind[4] = 2'd2; p_take[4] = 0;
    p_kind[9] = 2'd1; p_take[9] = 1; p_imm[9] = 8'd20; p_a[9] = 64'h0123_4567_89AB_CDEF;
    p_kind[31] = 2'd2; p_take[31] = 0;
    p_kind[32] = 2'd2; p_take[32] = 1; p_a[32] = 64'h5555_AAAA_5555_AAAA;
    run_prog(-1);
  endtask

  // R6 R8: nested calls near the end of the buffer with wrapping targets
  task automatic t_nested_wrap();
    clear_prog();
    p_kind[0] = 2'd1; p_take[0] = 1; p_imm[0] = 8'd250; p_a[0] = 64'hA0;
    p_kind[252] = 2'd1; p_take[252] = 1; p_imm[252] = 8'd255; p_a[252] = 64'hB1;
    p_kind[509] = 2'd1; p_take[509] = 1; p_imm[509] = 8'd1; p_a[509] = 64'hC2;
    p_kind[0] = 2'd1;
    p_kind[1] = 2'd2; p_take[1] = 1; p_a[1] = 64'hF0F0;
    p_kind[510] = 2'd2; p_take[510] = 1; p_a[510] = 64'h0F0F;
    p_kind[253] = 2'd2; p_take[253] = 1; p_a[253] = 64'h7777;
    run_prog(-1);
  endtask

  // R10: deep call chain reaching the stack bound, then returns
  task automatic t_overflow();
    clear_prog();
    for (int i = 0; i < 300; i += 2) begin
      p_kind[i] = 2'd1; p_take[i] = 1; p_imm[i] = 8'd0; p_a[i] = 64'(i) * 64'h1_0001;
    end
    for (int i = 300; i < N; i++) begin
      p_kind[i] = 2'd2; p_take[i] = 1; p_a[i] = 64'hC0DE_0000 + 64'(i);
    end
    run_prog(-1);
  endtask

  // mixed pseudo-random program covering all paths together
  task automatic t_mixed();
    logic [31:0] s;
    s = 32'h1234_5678;
    for (int i = 0; i < N; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      p_kind[i] = s[1:0];
      p_take[i] = s[4] | s[5];
      p_imm[i]  = s[15:8];
      p_a[i]    = {s, ~s ^ 32'(i)};
    end
    run_prog(123);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_plain_wrap();
    t_call_ret();
    t_nested_wrap();
    t_overflow();
    t_mixed();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule